// File: doc/BRIEF.md
# Clipped Midpoint Circle Rasterizer

This engine draws the outline of a circle into a 160 by 120 pixel framebuffer. It writes one pixel per clock through an x, y, colour and plot strobe. The caller presents a centre, a radius and a colour, then raises `start` and holds it. The engine captures those inputs and steps an integer decision variable one radial step at a time. For each step it emits the eight mirror-image points of that step in a fixed sequence, using one clock per point. It never fills the interior.

A point whose x falls outside 0..159 or whose y falls outside 0..119 is never written. Its cycle is still spent, so the total run time depends only on the radius and not on where the circle sits. When the last point has gone out, `done` rises and stays high until the caller drops `start`. The engine is then ready for a new `start` on the very next cycle.

Top module: `circ_raster`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `done` and `vga_plot` are both 0. A reset taken in the middle of a drawing abandons that drawing.
- R2: Set the offsets to a = radius and b = 0. Each step produces eight points, in this order: (cx+a,cy+b), (cx+b,cy+a), (cx-a,cy+b), (cx-b,cy+a), (cx-a,cy-b), (cx-b,cy-a), (cx+a,cy-b), (cx+b,cy-a). Every on-screen point appears on the outputs in that order.
- R3: The decision value starts at 1 - radius. After each group of eight points, b increases by 1. If the decision value is at most 0, it grows by 2b+1, using the new b. Otherwise a decreases by 1 and the decision value grows by 2(b-a)+1, using the new a and b. Stepping continues while b <= a. A drawing therefore contains exactly 8 times the number of steps in points, including the clipped ones.
- R4: A point with x outside 0..159 or y outside 0..119 is never plotted. That point still takes its own cycle with `vga_plot` low.
- R5: Every plotted pixel carries the colour captured at start.
- R6: `done` rises within 8N + 10 cycles of `start` rising, where N is the number of steps. The first pixel appears 2 cycles after the start edge, and `done` appears 8N + 1 cycles after it.
- R7: `done` stays high while `start` stays high. It falls on the cycle after `start` falls. A `start` raised again immediately after that begins a new drawing.
- R8: Centre, radius and colour are captured when a drawing begins. Changes to them during the drawing have no effect on the pixels drawn.
- R9: A radius of 0 produces a single step: eight points, all at the centre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | request a drawing; held high until done |
| colour | input | 3 | drawing colour |
| centre_x | input | 8 | centre x, may lie off screen |
| centre_y | input | 7 | centre y, may lie off screen |
| radius | input | 8 | radius in pixels |
| done | output | 1 | drawing finished |
| vga_x | output | 8 | pixel x |
| vga_y | output | 7 | pixel y |
| vga_colour | output | 3 | pixel colour |
| vga_plot | output | 1 | pixel write strobe |

## Verification
The first point of a drawing reaches the outputs 2 cycles after the cycle in which `start` is first seen. The point of sequence index k appears k cycles after the first, and `done` appears 8N + 1 cycles after the start edge. The bench drives inputs on falling edges and samples on every falling edge between start and `done`. It compares each plotted pixel, in order, against a point list worked out separately from R2 and R3. It measures the arrival of `done` against the 8N + 10 limit. After dropping `start`, it samples one falling edge later to see `done` low.

// File: rtl/circ_pkg.sv
package circ_pkg;
  localparam int XW   = 8;
  localparam int YW   = 7;
  localparam int RW   = 8;
  localparam int CLRW = 3;
  localparam int SCR_W = 160;
  localparam int SCR_H = 120;
  // signed coordinate width: widest input plus carry plus sign
  localparam int CW  = ((XW > RW) ? XW : RW) + 2;
  // decision value width
  localparam int CRW = RW + 4;

  typedef enum logic [1:0] {ST_IDLE, ST_DRAW, ST_DONE} circ_state_t;
endpackage

// File: rtl/circ_octant.sv
module circ_octant
  import circ_pkg::*;
(
  input  logic [2:0]           oct,
  input  logic [XW-1:0]        cx,
  input  logic [YW-1:0]        cy,
  input  logic signed [CW-1:0] ox,
  input  logic signed [CW-1:0] oy,
  output logic [XW-1:0]        px,
  output logic [YW-1:0]        py,
  output logic                 on_screen
);
  localparam logic signed [CW-1:0] XLIM = CW'(SCR_W);
  localparam logic signed [CW-1:0] YLIM = CW'(SCR_H);

  logic signed [CW-1:0] cxs, cys, dx, dy, sx, sy;
  logic xneg, yneg;

  always_comb begin
    cxs  = {{(CW-XW){1'b0}}, cx};
    cys  = {{(CW-YW){1'b0}}, cy};
    dx   = oct[0] ? oy : ox;
    dy   = oct[0] ? ox : oy;
    xneg = oct[2] ^ oct[1];
    yneg = oct[2];
    sx   = xneg ? (cxs - dx) : (cxs + dx);
    sy   = yneg ? (cys - dy) : (cys + dy);
    on_screen = (sx >= 0) && (sx < XLIM) && (sy >= 0) && (sy < YLIM);
    px = sx[XW-1:0];
    py = sy[YW-1:0];
  end
endmodule

// File: rtl/circ_step.sv
module circ_step
  import circ_pkg::*;
(
  input  logic signed [CW-1:0]  ox,
  input  logic signed [CW-1:0]  oy,
  input  logic signed [CRW-1:0] crit,
  output logic signed [CW-1:0]  nox,
  output logic signed [CW-1:0]  noy,
  output logic signed [CRW-1:0] ncrit,
  output logic                  last
);
  logic signed [CRW-1:0] noy_e, nox_e;

  always_comb begin
    noy   = oy + CW'(1);
    nox   = (crit <= 0) ? ox : (ox - CW'(1));
    noy_e = {{(CRW-CW){noy[CW-1]}}, noy};
    nox_e = {{(CRW-CW){nox[CW-1]}}, nox};
    if (crit <= 0) ncrit = crit + (noy_e <<< 1) + CRW'(1);
    else           ncrit = crit + ((noy_e - nox_e) <<< 1) + CRW'(1);
    last  = noy > nox;
  end
endmodule

// File: rtl/circ_raster.sv
module circ_raster
  import circ_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CLRW-1:0] colour,
  input  logic [XW-1:0]   centre_x,
  input  logic [YW-1:0]   centre_y,
  input  logic [RW-1:0]   radius,
  output logic            done,
  output logic [XW-1:0]   vga_x,
  output logic [YW-1:0]   vga_y,
  output logic [CLRW-1:0] vga_colour,
  output logic            vga_plot
);
  circ_state_t           state;
  logic [2:0]            oct;
  logic [XW-1:0]         cx_q;
  logic [YW-1:0]         cy_q;
  logic [CLRW-1:0]       col_q;
  logic signed [CW-1:0]  ox, oy, nox, noy;
  logic signed [CRW-1:0] crit, ncrit;
  logic                  last;
  logic [XW-1:0]         px;
  logic [YW-1:0]         py;
  logic                  on_screen;

  circ_octant u_oct (
    .oct(oct), .cx(cx_q), .cy(cy_q), .ox(ox), .oy(oy),
    .px(px), .py(py), .on_screen(on_screen)
  );

  circ_step u_step (
    .ox(ox), .oy(oy), .crit(crit),
    .nox(nox), .noy(noy), .ncrit(ncrit), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      oct        <= '0;
      cx_q       <= '0;
      cy_q       <= '0;
      col_q      <= '0;
      ox         <= '0;
      oy         <= '0;
      crit       <= '0;
      done       <= 1'b0;
      vga_x      <= '0;
      vga_y      <= '0;
      vga_colour <= '0;
      vga_plot   <= 1'b0;
    end else begin
      vga_plot <= 1'b0;
      case (state)
        ST_IDLE: begin
          done <= 1'b0;
          if (start) begin
            cx_q  <= centre_x;
            cy_q  <= centre_y;
            col_q <= colour;
            ox    <= {{(CW-RW){1'b0}}, radius};
            oy    <= '0;
            crit  <= CRW'(1) - {{(CRW-RW){1'b0}}, radius};
            oct   <= '0;
            state <= ST_DRAW;
          end
        end
        ST_DRAW: begin
          vga_plot   <= on_screen;
          vga_x      <= px;
          vga_y      <= py;
          vga_colour <= col_q;
          oct        <= oct + 3'd1;
          if (oct == 3'd7) begin
            ox   <= nox;
            oy   <= noy;
            crit <= ncrit;
            if (last) begin
              state <= ST_DONE;
              done  <= 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (!start) begin
            done  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/circ_raster_chk.sv
module circ_raster_chk
  import circ_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic [XW-1:0] vga_x,
  input logic [YW-1:0] vga_y,
  input logic          vga_plot
);
  // R4
  plot_x_on_screen_chk: assert property (@(posedge clk) disable iff (rst)
    vga_plot |-> (int'(vga_x) < SCR_W));
  // R4
  plot_y_on_screen_chk: assert property (@(posedge clk) disable iff (rst)
    vga_plot |-> (int'(vga_y) < SCR_H));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> done);
  // R7
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);
  // R1
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !vga_plot);
endmodule

bind circ_raster circ_raster_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .vga_x(vga_x), .vga_y(vga_y), .vga_plot(vga_plot)
);

// File: tb/circ_raster_tb_top.sv
module circ_raster_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam int MAXP = 2048;
  // {cx[7:0], cy[6:0], radius[7:0], colour[2:0]}
  localparam logic [25:0] VECS [NV] = '{
    {8'd80,  7'd60,  8'd40,  3'd2},
    {8'd0,   7'd0,   8'd10,  3'd5},
    {8'd159, 7'd119, 8'd30,  3'd7},
    {8'd80,  7'd60,  8'd0,   3'd3},
    {8'd10,  7'd110, 8'd100, 3'd1},
    {8'd200, 7'd100, 8'd50,  3'd4},
    {8'd80,  7'd60,  8'd255, 3'd6}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] colour = '0;
  logic [7:0] centre_x = '0;
  logic [6:0] centre_y = '0;
  logic [7:0] radius = '0;
  logic done, vga_plot;
  logic [7:0] vga_x;
  logic [6:0] vga_y;
  logic [2:0] vga_colour;

  int checks = 0, fails = 0;
  int exp_x [MAXP];
  int exp_y [MAXP];
  int n_exp, n_tot;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_raster dut_i (
    .clk(clk), .rst(rst), .start(start), .colour(colour),
    .centre_x(centre_x), .centre_y(centre_y), .radius(radius),
    .done(done), .vga_x(vga_x), .vga_y(vga_y),
    .vga_colour(vga_colour), .vga_plot(vga_plot)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model(input int cx, input int cy, input int r);
    int a, b, d, px, py;
    a = r; b = 0; d = 1 - r; n_exp = 0; n_tot = 0;
    while (b <= a) begin
      for (int k = 0; k < 8; k++) begin
        case (k)
          0: begin px = cx + a; py = cy + b; end
          1: begin px = cx + b; py = cy + a; end
          2: begin px = cx - a; py = cy + b; end
          3: begin px = cx - b; py = cy + a; end
          4: begin px = cx - a; py = cy - b; end
          5: begin px = cx - b; py = cy - a; end
          6: begin px = cx + a; py = cy - b; end
          default: begin px = cx + b; py = cy - a; end
        endcase
        n_tot++;
        if (px >= 0 && px < 160 && py >= 0 && py < 120) begin
          exp_x[n_exp] = px; exp_y[n_exp] = py; n_exp++;
        end
      end
      b = b + 1;
      if (d <= 0) d = d + 2*b + 1;
      else begin a = a - 1; d = d + 2*(b - a) + 1; end
    end
  endtask

  // draw one circle; scramble changes the inputs mid-drawing (R8)
  task automatic run(input int cx, input int cy, input int r, input int col, input bit scramble);
    int cyc, got, bad, badcol, first_bad_act, first_bad_exp;
    model(cx, cy, r);
    centre_x = 8'(cx); centre_y = 7'(cy); radius = 8'(r); colour = 3'(col);
    start = 1'b1;
    cyc = 0; got = 0; bad = 0; badcol = 0; first_bad_act = 0; first_bad_exp = 0;
    while (cyc < n_tot + 40) begin
      @(negedge clk);
      cyc++;
      if (scramble && cyc == 4) begin
        centre_x = 8'(cx + 17); centre_y = 7'(cy + 9); radius = 8'(r + 3); colour = 3'(col + 1);
      end
      if (vga_plot) begin
        if (got < n_exp) begin
          if (int'(vga_x) != exp_x[got] || int'(vga_y) != exp_y[got]) begin
            if (bad == 0) begin
              first_bad_act = int'(vga_x)*1000 + int'(vga_y);
              first_bad_exp = exp_x[got]*1000 + exp_y[got];
            end
            bad++;
          end
        end
        if (int'(vga_colour) != col) badcol++;
        got++;
      end
      if (done) break;
    end
    check(bad == 0, scramble ? "R8 pixel sequence (xxx*1000+yy)" : "R2 pixel sequence (xxx*1000+yy)",
          first_bad_act, first_bad_exp);
    check(got == n_exp, "R4 plotted count", got, n_exp);
    check(badcol == 0, "R5 colour mismatches", badcol, 0);
    check(done && cyc == n_tot + 1, "R3 cycles to done (8N+1)", cyc, n_tot + 1);
    check(done && cyc <= n_tot + 10, "R6 done within budget", cyc, n_tot + 10);
    @(negedge clk);
    check(done == 1'b1, "R7 done held while start high", done, 1);
    check(vga_plot == 1'b0, "R4 no plot after done", vga_plot, 0);
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R7 done drops after start", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(vga_plot == 1'b0, "R1 plot in reset", vga_plot, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && vga_plot == 1'b0, "R1 idle after reset", {done, vga_plot}, 0);

    for (int i = 0; i < NV; i++)
      run(int'(VECS[i][25:18]), int'(VECS[i][17:11]), int'(VECS[i][10:3]), int'(VECS[i][2:0]), 1'b0);

    // R9 radius zero: eight points at the centre
    model(50, 40, 0);
    check(n_tot == 8, "R9 model point count", n_tot, 8);
    run(50, 40, 0, 2, 1'b0);

    // R8 inputs changed mid-drawing are ignored
    run(70, 50, 20, 5, 1'b1);

    // R7 immediate restart after done drops (back-to-back runs)
    run(30, 30, 5, 1, 1'b0);
    run(31, 30, 6, 6, 1'b0);

    // R1 reset in mid drawing
    centre_x = 8'd80; centre_y = 7'd60; radius = 8'd40; colour = 3'd2;
    start = 1'b1;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; start = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && vga_plot == 1'b0, "R1 reset aborts drawing", {done, vga_plot}, 0);
    repeat (5) @(negedge clk);
    check(vga_plot == 1'b0, "R1 idle stays quiet", vga_plot, 0);
    run(80, 60, 12, 3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule